// File: doc/BRIEF.md
# Operand Request Splitter

This block takes operand requests from an address-generation stage and turns each one into the sequence of commands a memory controller needs. A request carries an operation type, a start address and a length of 1 to 256 bytes. Accepted requests wait in a three-entry queue. Each one receives one of six operand buffers, and the buffer id goes with every command the request produces. The rotate amount the data path needs is reported one cycle after acceptance.

The commands that a request expands into depend on its type and on the boundaries the operand crosses. A doubleword is 8 bytes, a line is 256 bytes and a page is 4 KB. Fetch-like operands produce one command per doubleword touched. Entering a new line uses an address-increment command instead, and entering a new page adds a page-alert command ahead of it. Store-like operands produce one exclusive-access command per line touched.

Only one command is outstanding at a time. A command the controller does not acknowledge within a fixed window is sent again. A storage-to-storage pair must arrive part one then part two, and any request that breaks this pairing is dropped.

Top module: `ofs_top`

## Requirements
- R1: `acc_hold` is 1 when the queue holds 3 requests, `acc_block` is 1 when no buffer is free, and `acc_avail` is 1 only when both are 0. A request is accepted only in a cycle where `req_valid` and `acc_avail` are both 1 and its type is allowed. Any other request is ignored.
- R2: The type codes are 0 fetch, 1 store, 2 store-fetch, 3 storage-to-storage part one and 4 part two. Codes 5 to 7 are ignored. After a part one is accepted, only a part two is accepted. A part two is ignored when no part one is pending.
- R3: In the cycle after a request is accepted, `alloc_valid` pulses for one cycle. `alloc_id` is the lowest-numbered free buffer. `rot_amt` is (address bits 2:0 + length-minus-one + 1) mod 8.
- R4: There are six buffers. A buffer stays busy until its bit of `buf_release` is pulsed, and it is free from the next cycle.
- R5: Fetch, store-fetch and part one use the fetch rule. The first command is code 0 (initial) at the start address. Each later doubleword touched gets code 1 (continuation) at its aligned address, unless that doubleword starts a line.
- R6: Under the fetch rule, a doubleword that starts a line gets code 2 (address increment) at that address. If it also starts a page, code 3 (page alert) at the same address comes immediately before the code 2 command.
- R7: Store and part two use the store rule. The first command is code 4 at the start address. Each further line touched gets code 4 at its line-aligned address.
- R8: `mreq_valid` is a single-cycle pulse. After an acknowledge, the next command of the same request follows two cycles after the acknowledged command, when the acknowledge arrives in the cycle right after it. Requests are served in arrival order, and `mreq_buf` carries the request's buffer id.
- R9: If `mack` does not arrive within ACK_WIN (4) cycles after a command, the same command and address are sent again ACK_WIN+1 cycles after the first send.
- R10: After reset, `acc_avail` is 1, `acc_block` and `acc_hold` are 0, and `mreq_valid` and `alloc_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Request type code |
| req_addr | input | 32 | Operand start address |
| req_len | input | 8 | Operand length minus one |
| acc_avail | output | 1 | Ready to accept a request |
| acc_block | output | 1 | No operand buffer free |
| acc_hold | output | 1 | Request queue full |
| alloc_valid | output | 1 | Acceptance pulse, one cycle after the request |
| alloc_id | output | 3 | Buffer given to the accepted request |
| rot_amt | output | 3 | Rotate amount for the accepted request |
| buf_release | input | 6 | Per-buffer free pulse |
| mreq_valid | output | 1 | Command to memory controller |
| mreq_cmd | output | 3 | Command code |
| mreq_addr | output | 32 | Command address |
| mreq_buf | output | 3 | Buffer id of the command |
| mack | input | 1 | Acknowledge from memory controller |

## Verification
The hardest state to reach is a full queue while a command is being resent. The bench holds back every acknowledge, so the head request keeps timing out and resending. While that runs, it pushes three requests back to back, then sends a fourth to confirm it is refused. Releasing the acknowledges afterwards shows the queue draining in arrival order. A separate scenario drops exactly one acknowledge to measure the resend spacing, and the page case is placed so that the page alert and the line increment fall on the same address.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
    localparam logic [2:0] OP_FETCH   = 3'd0;
    localparam logic [2:0] OP_STORE   = 3'd1;
    localparam logic [2:0] OP_STFETCH = 3'd2;
    localparam logic [2:0] OP_SS1     = 3'd3;
    localparam logic [2:0] OP_SS2     = 3'd4;

    localparam logic [2:0] MC_INIT  = 3'd0;
    localparam logic [2:0] MC_CONT  = 3'd1;
    localparam logic [2:0] MC_AINC  = 3'd2;
    localparam logic [2:0] MC_PAGE  = 3'd3;
    localparam logic [2:0] MC_STORE = 3'd4;

    typedef enum logic [1:0] {SQ_IDLE, SQ_SEND, SQ_WAIT} seq_st_e;
endpackage

// File: rtl/ofs_queue.sv
module ofs_queue #(
    parameter int DEPTH = 3,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } qst_t;

    qst_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        if (push) begin
            q_d.mem[q_q.wr] = din;
            q_d.wr = (q_q.wr == PW'(DEPTH - 1)) ? '0 : q_q.wr + 1'b1;
        end
        if (pop) begin
            q_d.rd = (q_q.rd == PW'(DEPTH - 1)) ? '0 : q_q.rd + 1'b1;
        end
        q_d.cnt = q_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign dout  = q_q.mem[q_q.rd];
    assign full  = (q_q.cnt == CW'(DEPTH));
    assign empty = (q_q.cnt == '0);
endmodule

// File: rtl/ofs_bufpool.sv
module ofs_bufpool #(
    parameter int NBUF = 6,
    localparam int BW  = $clog2(NBUF)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc,
    input  logic [NBUF-1:0] release_mask,
    output logic            any_free,
    output logic [BW-1:0]   free_id
);
    logic [NBUF-1:0] busy_q, busy_d, set_vec;

    always_comb begin
        any_free = 1'b0;
        free_id  = '0;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (!busy_q[i]) begin
                any_free = 1'b1;
                free_id  = BW'(i);
            end
        end
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_set
        assign set_vec[g] = alloc && any_free && (free_id == BW'(g));
    end

    always_comb begin
        busy_d = (busy_q & ~release_mask) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_d;
    end
endmodule

// File: rtl/ofs_seq.sv
module ofs_seq
    import ofs_pkg::*;
#(
    parameter int AW      = 32,
    parameter int LEN_W   = 8,
    parameter int BUF_W   = 3,
    parameter int DW_LG   = 3,
    parameter int LINE_LG = 8,
    parameter int PAGE_LG = 12,
    parameter int ACK_WIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             head_valid,
    input  logic [2:0]       head_op,
    input  logic [AW-1:0]    head_addr,
    input  logic [LEN_W-1:0] head_len,
    input  logic [BUF_W-1:0] head_buf,
    input  logic             mack,
    output logic             mreq_valid,
    output logic [2:0]       mreq_cmd,
    output logic [AW-1:0]    mreq_addr,
    output logic [BUF_W-1:0] mreq_buf,
    output logic             pop
);
    localparam int TW = $clog2(ACK_WIN + 1);

    typedef struct packed {
        seq_st_e       st;
        logic [2:0]    cmd;
        logic [AW:0]   cur;
        logic          page_sent;
        logic [TW-1:0] timer;
    } sst_t;

    sst_t s_q, s_d;

    logic        store_rule;
    logic [AW:0] last_byte;
    logic [AW:0] nxt;

    function automatic logic [2:0] plan_cmd(input logic first, input logic st_rule,
                                            input logic [AW:0] c, input logic pg_sent);
        logic [2:0] r;
        if (first)                            r = st_rule ? MC_STORE : MC_INIT;
        else if (st_rule)                     r = MC_STORE;
        else if (c[LINE_LG-1:0] == '0) begin
            if (c[PAGE_LG-1:0] == '0 && !pg_sent) r = MC_PAGE;
            else                                  r = MC_AINC;
        end
        else                                  r = MC_CONT;
        return r;
    endfunction

    assign store_rule = (head_op == OP_STORE) || (head_op == OP_SS2);
    assign last_byte  = {1'b0, head_addr} + (AW + 1)'(head_len);

    always_comb begin
        if (store_rule) nxt = {s_q.cur[AW:LINE_LG] + 1'b1, LINE_LG'(0)};
        else            nxt = {s_q.cur[AW:DW_LG] + 1'b1, DW_LG'(0)};
    end

    always_comb begin
        s_d = s_q;
        pop = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (head_valid) begin
                    s_d.cur       = {1'b0, head_addr};
                    s_d.page_sent = 1'b0;
                    s_d.cmd       = plan_cmd(1'b1, store_rule, {1'b0, head_addr}, 1'b0);
                    s_d.st        = SQ_SEND;
                end
            end
            SQ_SEND: begin
                s_d.st    = SQ_WAIT;
                s_d.timer = '0;
            end
            SQ_WAIT: begin
                if (mack) begin
                    if (s_q.cmd == MC_PAGE) begin
                        s_d.page_sent = 1'b1;
                        s_d.cmd       = plan_cmd(1'b0, store_rule, s_q.cur, 1'b1);
                        s_d.st        = SQ_SEND;
                    end else if (nxt > last_byte) begin
                        pop      = 1'b1;
                        s_d.st   = SQ_IDLE;
                    end else begin
                        s_d.cur       = nxt;
                        s_d.page_sent = 1'b0;
                        s_d.cmd       = plan_cmd(1'b0, store_rule, nxt, 1'b0);
                        s_d.st        = SQ_SEND;
                    end
                end else if (s_q.timer == TW'(ACK_WIN - 1)) begin
                    s_d.st = SQ_SEND;
                end else begin
                    s_d.timer = s_q.timer + 1'b1;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, cmd: '0, cur: '0, page_sent: 1'b0, timer: '0};
        else        s_q <= s_d;
    end

    assign mreq_valid = (s_q.st == SQ_SEND);
    assign mreq_cmd   = s_q.cmd;
    assign mreq_addr  = s_q.cur[AW-1:0];
    assign mreq_buf   = head_buf;
endmodule

// File: rtl/ofs_top.sv
module ofs_top
    import ofs_pkg::*;
#(
    parameter int AW      = 32,
    parameter int LEN_W   = 8,
    parameter int QDEPTH  = 3,
    parameter int NBUF    = 6,
    parameter int DW_LG   = 3,
    parameter int LINE_LG = 8,
    parameter int PAGE_LG = 12,
    parameter int ACK_WIN = 4,
    localparam int BUF_W  = $clog2(NBUF),
    localparam int EW     = 3 + AW + LEN_W + BUF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [AW-1:0]    req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             acc_avail,
    output logic             acc_block,
    output logic             acc_hold,
    output logic             alloc_valid,
    output logic [BUF_W-1:0] alloc_id,
    output logic [DW_LG-1:0] rot_amt,
    input  logic [NBUF-1:0]  buf_release,
    output logic             mreq_valid,
    output logic [2:0]       mreq_cmd,
    output logic [AW-1:0]    mreq_addr,
    output logic [BUF_W-1:0] mreq_buf,
    input  logic             mack
);
    typedef struct packed {
        logic             ss_pend;
        logic             av;
        logic [BUF_W-1:0] aid;
        logic [DW_LG-1:0] rot;
    } tst_t;

    tst_t t_q, t_d;

    logic             q_full, q_empty, q_pop, any_free, allowed, accept;
    logic [BUF_W-1:0] free_id;
    logic [EW-1:0]    q_din, q_dout;
    logic [2:0]       h_op;
    logic [AW-1:0]    h_addr;
    logic [LEN_W-1:0] h_len;
    logic [BUF_W-1:0] h_buf;

    assign acc_hold  = q_full;
    assign acc_block = !any_free;
    assign acc_avail = !q_full && any_free;

    assign allowed = t_q.ss_pend ? (req_op == OP_SS2) : (req_op <= OP_SS1);
    assign accept  = req_valid && acc_avail && allowed;

    always_comb begin
        t_d    = t_q;
        t_d.av = accept;
        if (accept) begin
            t_d.aid = free_id;
            t_d.rot = req_addr[DW_LG-1:0] + req_len[DW_LG-1:0] + 1'b1;
            if (req_op == OP_SS1) t_d.ss_pend = 1'b1;
            if (req_op == OP_SS2) t_d.ss_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign alloc_valid = t_q.av;
    assign alloc_id    = t_q.aid;
    assign rot_amt     = t_q.rot;

    assign q_din = {req_op, req_addr, req_len, free_id};
    assign {h_op, h_addr, h_len, h_buf} = q_dout;

    ofs_queue #(.DEPTH(QDEPTH), .W(EW)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(accept), .din(q_din), .pop(q_pop),
        .dout(q_dout), .full(q_full), .empty(q_empty)
    );

    ofs_bufpool #(.NBUF(NBUF)) u_pool (
        .clk(clk), .rst_n(rst_n), .alloc(accept), .release_mask(buf_release),
        .any_free(any_free), .free_id(free_id)
    );

    ofs_seq #(
        .AW(AW), .LEN_W(LEN_W), .BUF_W(BUF_W), .DW_LG(DW_LG),
        .LINE_LG(LINE_LG), .PAGE_LG(PAGE_LG), .ACK_WIN(ACK_WIN)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .head_valid(!q_empty), .head_op(h_op),
        .head_addr(h_addr), .head_len(h_len), .head_buf(h_buf), .mack(mack),
        .mreq_valid(mreq_valid), .mreq_cmd(mreq_cmd), .mreq_addr(mreq_addr),
        .mreq_buf(mreq_buf), .pop(q_pop)
    );
endmodule

// File: rtl/ofs_chk.sv
module ofs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       acc_hold,
    input logic       acc_block,
    input logic       alloc_valid,
    input logic       mreq_valid,
    input logic [2:0] mreq_cmd
);
    // R1: a full queue refuses the request
    a_r1_no_accept_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_hold) |=> !alloc_valid);

    // R1, R4: no free buffer refuses the request
    a_r1_no_accept_block: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_block) |=> !alloc_valid);

    // R3: allocation pulse only follows a presented request
    a_r3_alloc_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid |-> $past(req_valid));

    // R8: command pulse lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |=> !mreq_valid);

    // R5, R7: only defined command codes leave the block
    a_r5_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_valid |-> (mreq_cmd <= 3'd4));
endmodule

bind ofs_top ofs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_hold(acc_hold),
    .acc_block(acc_block), .alloc_valid(alloc_valid),
    .mreq_valid(mreq_valid), .mreq_cmd(mreq_cmd)
);

// File: tb/tb_ofs_top.sv
module tb_ofs_top;
    localparam int CLK_PERIOD = 10;
    localparam int ACK_WIN    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic        acc_avail, acc_block, acc_hold, alloc_valid;
    logic [2:0]  alloc_id, rot_amt;
    logic [5:0]  buf_release = '0;
    logic        mreq_valid;
    logic [2:0]  mreq_cmd, mreq_buf;
    logic [31:0] mreq_addr;
    logic        mack = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [2:0]  log_cmd [64];
    logic [31:0] log_addr [64];
    logic [2:0]  log_buf [64];
    int          log_cyc [64];
    int          log_n = 0;
    int          drop_n = 0;
    int          ack_en = 1;
    int          cd = 0;

    logic [2:0]  exp_cmd [64];
    logic [31:0] exp_addr [64];
    int          exp_n;

    logic        got_av;
    logic [2:0]  got_id, got_rot;

    ofs_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .acc_avail(acc_avail),
        .acc_block(acc_block), .acc_hold(acc_hold), .alloc_valid(alloc_valid),
        .alloc_id(alloc_id), .rot_amt(rot_amt), .buf_release(buf_release),
        .mreq_valid(mreq_valid), .mreq_cmd(mreq_cmd), .mreq_addr(mreq_addr),
        .mreq_buf(mreq_buf), .mack(mack)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc++;

    // memory controller model: logs commands, acknowledges after one cycle
    always @(negedge clk) begin
        mack = 1'b0;
        if (mreq_valid) begin
            if (log_n < 64) begin
                log_cmd[log_n]  = mreq_cmd;
                log_addr[log_n] = mreq_addr;
                log_buf[log_n]  = mreq_buf;
                log_cyc[log_n]  = cyc;
                log_n++;
            end
            if (drop_n > 0)      drop_n--;
            else if (ack_en != 0) cd = 1;
        end else if (cd > 0) begin
            cd--;
            if (cd == 0) mack = 1'b1;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic do_req(input logic [2:0] op, input logic [31:0] a, input logic [7:0] lm1);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_len = lm1;
        @(posedge clk);
        #1;
        got_av = alloc_valid; got_id = alloc_id; got_rot = rot_amt;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic release_all();
        @(negedge clk); buf_release = 6'h3f;
        @(negedge clk); buf_release = '0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_exp(input logic [2:0] c, input longint a);
        exp_cmd[exp_n]  = c;
        exp_addr[exp_n] = a[31:0];
        exp_n++;
    endtask

    // expected command list from the fetch and store rules
    task automatic expand(input int op, input longint a, input int lm1);
        bit st;
        longint last;
        exp_n = 0;
        st = (op == 1 || op == 4);
        last = a + lm1;
        push_exp(st ? 3'd4 : 3'd0, a);
        if (st) begin
            for (longint l = ((a >> 8) + 1) << 8; l <= last; l += 256) push_exp(3'd4, l);
        end else begin
            for (longint d = ((a >> 3) + 1) << 3; d <= last; d += 8) begin
                if (d % 256 == 0) begin
                    if (d % 4096 == 0) push_exp(3'd3, d);
                    push_exp(3'd2, d);
                end else push_exp(3'd1, d);
            end
        end
    endtask

    task automatic cmp_log(input string tag, input int base);
        check(log_n == base + exp_n, {tag, " count"}, log_n, base + exp_n);
        for (int i = 0; i < exp_n && base + i < log_n; i++) begin
            check(log_cmd[base + i] == exp_cmd[i], {tag, " cmd"}, log_cmd[base + i], exp_cmd[i]);
            check(log_addr[base + i] == exp_addr[i], {tag, " addr"}, log_addr[base + i], exp_addr[i]);
        end
    endtask

    task automatic run_case(input logic [2:0] op, input logic [31:0] a, input logic [7:0] lm1,
                            input string tag);
        release_all();
        log_n = 0;
        do_req(op, a, lm1);
        check(got_av == 1'b1, "R3 alloc pulse", got_av, 1);
        check(got_id == 3'd0, "R3 lowest buffer", got_id, 0);
        check(got_rot == 3'((a[2:0] + lm1 + 1) & 7), "R3 rotate", got_rot, (a[2:0] + lm1 + 1) & 7);
        wait_cycles(150);
        expand(op, a, lm1);
        cmp_log(tag, 0);
        if (log_n > 0) check(log_buf[0] == got_id, "R8 buffer id", log_buf[0], got_id);
    endtask

    task automatic t_reset();
        check(acc_avail == 1'b1, "R10 avail", acc_avail, 1);
        check(acc_block == 1'b0, "R10 block", acc_block, 0);
        check(acc_hold == 1'b0, "R10 hold", acc_hold, 0);
        check(mreq_valid == 1'b0, "R10 mreq", mreq_valid, 0);
        check(alloc_valid == 1'b0, "R10 alloc", alloc_valid, 0);
    endtask

    task automatic t_splits();
        run_case(3'd0, 32'h1000_0010, 8'd3, "R5 single dw");
        run_case(3'd0, 32'h0000_2005, 8'd19, "R5 continuation");
        if (log_n > 1) check(log_cyc[1] - log_cyc[0] == 2, "R8 ack spacing", log_cyc[1] - log_cyc[0], 2);
        run_case(3'd0, 32'h0000_30F8, 8'd15, "R6 line cross");
        run_case(3'd2, 32'h0000_9FF8, 8'd15, "R6 page cross");
        run_case(3'd1, 32'h0000_60F0, 8'd255, "R7 store two lines");
        run_case(3'd1, 32'h0000_6010, 8'd7, "R7 store one line");
    endtask

    task automatic t_pairing();
        release_all();
        log_n = 0;
        do_req(3'd4, 32'h0000_7100, 8'd0);
        check(got_av == 1'b0, "R2 lone part two ignored", got_av, 0);
        do_req(3'd3, 32'h0000_7000, 8'd0);
        check(got_av == 1'b1, "R2 part one accepted", got_av, 1);
        do_req(3'd0, 32'h0000_7200, 8'd0);
        check(got_av == 1'b0, "R2 fetch between pair ignored", got_av, 0);
        do_req(3'd6, 32'h0000_7300, 8'd0);
        check(got_av == 1'b0, "R2 bad code ignored", got_av, 0);
        do_req(3'd4, 32'h0000_80F8, 8'd15);
        check(got_av == 1'b1, "R2 part two accepted", got_av, 1);
        wait_cycles(150);
        exp_n = 0;
        push_exp(3'd0, 64'h7000);
        push_exp(3'd4, 64'h80F8);
        push_exp(3'd4, 64'h8100);
        cmp_log("R2 pair commands", 0);
    endtask

    task automatic t_resend();
        release_all();
        log_n = 0;
        drop_n = 1;
        do_req(3'd0, 32'h0000_0500, 8'd0);
        wait_cycles(60);
        check(log_n == 2, "R9 resend count", log_n, 2);
        if (log_n == 2) begin
            check(log_addr[1] == log_addr[0], "R9 same addr", log_addr[1], log_addr[0]);
            check(log_cmd[1] == log_cmd[0], "R9 same cmd", log_cmd[1], log_cmd[0]);
            check(log_cyc[1] - log_cyc[0] == ACK_WIN + 1, "R9 resend gap",
                  log_cyc[1] - log_cyc[0], ACK_WIN + 1);
        end
    endtask

    task automatic t_buffers();
        release_all();
        for (int i = 0; i < 6; i++) begin
            do_req(3'd0, 32'h0000_0A00 + 32'(i * 16), 8'd0);
            check(got_id == 3'(i), "R4 allocation order", got_id, i);
            wait_cycles(10);
        end
        check(acc_block == 1'b1, "R4 all busy block", acc_block, 1);
        check(acc_avail == 1'b0, "R1 avail low when blocked", acc_avail, 0);
        do_req(3'd0, 32'h0000_0B00, 8'd0);
        check(got_av == 1'b0, "R1 blocked request ignored", got_av, 0);
        @(negedge clk); buf_release = 6'b000100;
        @(negedge clk); buf_release = '0;
        check(acc_block == 1'b0, "R4 release frees", acc_block, 0);
        do_req(3'd0, 32'h0000_0C00, 8'd0);
        check(got_id == 3'd2, "R3 lowest free after release", got_id, 2);
        wait_cycles(20);
    endtask

    task automatic t_queue_full();
        release_all();
        log_n = 0;
        ack_en = 0;
        do_req(3'd0, 32'h0000_0100, 8'd0);
        do_req(3'd0, 32'h0000_0200, 8'd0);
        do_req(3'd0, 32'h0000_0300, 8'd0);
        check(acc_hold == 1'b1, "R1 hold when full", acc_hold, 1);
        check(acc_avail == 1'b0, "R1 avail low when full", acc_avail, 0);
        check(acc_block == 1'b0, "R1 buffers remain", acc_block, 0);
        do_req(3'd0, 32'h0000_0400, 8'd0);
        check(got_av == 1'b0, "R1 full request ignored", got_av, 0);
        ack_en = 1;
        wait_cycles(100);
        check(acc_hold == 1'b0, "R1 hold clears", acc_hold, 0);
        check(log_n >= 3, "R8 drained", log_n, 3);
        if (log_n >= 3) begin
            check(log_addr[log_n - 3] == 32'h100, "R8 order 1", log_addr[log_n - 3], 32'h100);
            check(log_addr[log_n - 2] == 32'h200, "R8 order 2", log_addr[log_n - 2], 32'h200);
            check(log_addr[log_n - 1] == 32'h300, "R8 order 3", log_addr[log_n - 1], 32'h300);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_splits();
        t_pairing();
        t_resend();
        t_buffers();
        t_queue_full();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule